// File: doc/BRIEF.md
# Variable-width CRC input FIFO

This block is the write-side data queue that sits in front of a serial CRC sequencer. Software-style writes arrive as byte or halfword stores to a low and a high data register, and the block packs them into logical words whose width follows a 5-bit width code (data width = code + 1, from 1 to 32 bits). All packing modes share one physical store of 8 rows of 16 bits. That store is viewed as 16 bytes, 8 halfwords or 4 words, depending on the code.

A word is committed, and the valid-word level rises, when the byte lane that holds the top bit of the configured width is written. The sequencer sees the oldest committed word on `word_data`. Bits above the configured width read as zero. The sequencer removes the word with `pop`. Full and empty flags are kept beside the level. Deasserting `enable` flushes the queue. The width code may only change while the queue is empty.

Top module: `crcin_fifo`

## Requirements
- R1: After a synchronous reset, level is 0, empty is 1 and full is 0.
- R2: Logical depth is 16 for width codes 0..7, 8 for codes 8..15 and 4 for codes 16..31. Full is 1 exactly when the level equals that depth, and the level never exceeds it.
- R3: Byte mode (codes 0..7): a low-register write with at least one byte enable stores one entry. The entry comes from lane 0 (bits 7:0) if wr_be[0] is set, else from lane 1 (bits 15:8). Entries leave in write order. High-register writes are ignored.
- R4: Halfword mode (codes 8..15): a low-register write stores its enabled lanes into the pending entry. It commits the entry only when wr_be[1] is set. High-register writes are ignored.
- R5: Word mode (codes 16..31): low-register writes fill bits 15:0 and high-register writes fill bits 31:16 of the pending entry. The entry commits on a high-register write that enables the lane holding the top bit: wr_be[0] for codes 16..23, wr_be[1] for codes 24..31.
- R6: Writes while full are dropped. They change neither the level nor any stored word.
- R7: A pop with level above 0 removes the head word and clears full. A pop while empty is ignored.
- R8: A commit and a pop in the same cycle leave the level unchanged.
- R9: With enable low, the queue is flushed at the next edge (level 0, empty 1, full 0). Writes and pops are ignored while enable stays low.
- R10: The data-register read port dreg_rdata is always zero.
- R11: word_data shows the head word with every bit above the configured width forced to zero.
- R12: If wr_lo and wr_hi are both asserted, only the low-register write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Module enable; low flushes the queue |
| width_code | input | 5 | Data width minus one |
| wr_lo | input | 1 | Write strobe for the low data register |
| wr_hi | input | 1 | Write strobe for the high data register |
| wr_be | input | 2 | Byte-lane enables of the write |
| wr_data | input | 16 | Write data |
| pop | input | 1 | Sequencer takes the head word |
| level | output | 5 | Number of committed words |
| full | output | 1 | Level equals the logical depth |
| empty | output | 1 | Level is zero |
| word_data | output | 32 | Head word, masked to the configured width |
| dreg_rdata | output | 16 | Data-register read value (always zero) |

## Verification
Level, full and empty are registered, so each is due at the first rising edge after the write or pop that changes it. word_data is read straight out of the store and follows the head pointer and store contents updated at that same edge. The bench drives every strobe on a falling edge, holds it across exactly one rising edge, and removes it and samples all outputs on the next falling edge. Each check therefore sees the state one edge after its stimulus. A walked vector table covers the packing rules of all three modes. Directed sequences then fill each mode to depth, write while full, push and pop together, and toggle enable.

// File: rtl/crcin_pkg.sv
package crcin_pkg;
  typedef enum logic [1:0] {
    M_BYTE = 2'd0,
    M_HALF = 2'd1,
    M_WORD = 2'd2
  } fmode_t;
endpackage

// File: rtl/crcin_mode_dec.sv
module crcin_mode_dec
  import crcin_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int ROWS   = 8,
  localparam int PHYS_W = 2 * LANE_W,
  localparam int DATA_W = 2 * PHYS_W,
  localparam int CODE_W = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(2 * ROWS + 1),
  localparam int PTR_W  = $clog2(2 * ROWS)
) (
  input  logic [CODE_W-1:0] code,
  output fmode_t            mode,
  output logic [CNT_W-1:0]  depth,
  output logic [PTR_W-1:0]  depth_m1,
  output logic [DATA_W-1:0] mask,
  output logic              hi_lane
);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(DATA_W - 1);

  always_comb begin
    if (code < CODE_W'(LANE_W)) begin
      mode  = M_BYTE;
      depth = CNT_W'(2 * ROWS);
    end else if (code < CODE_W'(PHYS_W)) begin
      mode  = M_HALF;
      depth = CNT_W'(ROWS);
    end else begin
      mode  = M_WORD;
      depth = CNT_W'(ROWS / 2);
    end
    depth_m1 = PTR_W'(depth - CNT_W'(1));
    mask     = {DATA_W{1'b1}} >> (TOP_CODE - code);
    hi_lane  = (code >= CODE_W'(PHYS_W + LANE_W));
  end
endmodule

// File: rtl/crcin_store.sv
module crcin_store #(
  parameter int LANE_W = 8,
  parameter int ROWS   = 8,
  localparam int ROW_W = $clog2(ROWS)
) (
  input  logic                  clk,
  input  logic [1:0]            we,
  input  logic [ROW_W-1:0]      wrow,
  input  logic [2*LANE_W-1:0]   wdata,
  input  logic [ROW_W-1:0]      rrow_a,
  input  logic [ROW_W-1:0]      rrow_b,
  output logic [2*LANE_W-1:0]   rdata_a,
  output logic [2*LANE_W-1:0]   rdata_b
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] lmem [ROWS];
    always_ff @(posedge clk) begin
      if (we[g]) lmem[wrow] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata_a[g*LANE_W +: LANE_W] = lmem[rrow_a];
    assign rdata_b[g*LANE_W +: LANE_W] = lmem[rrow_b];
  end
endmodule

// File: rtl/crcin_wr_ctrl.sv
module crcin_wr_ctrl
  import crcin_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int ROWS   = 8,
  localparam int PHYS_W = 2 * LANE_W,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int PTR_W  = $clog2(2 * ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  fmode_t            mode,
  input  logic              hi_lane,
  input  logic              accept,
  input  logic [PTR_W-1:0]  wp,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [1:0]        be,
  input  logic [PHYS_W-1:0] data,
  output logic [1:0]        st_we,
  output logic [ROW_W-1:0]  st_row,
  output logic [PHYS_W-1:0] st_data,
  output logic              commit
);
  always_comb begin
    st_we   = 2'b00;
    st_row  = '0;
    st_data = data;
    commit  = 1'b0;
    if (accept) begin
      unique case (mode)
        M_BYTE: if (wr_lo && (be != 2'b00)) begin
          st_row  = wp[PTR_W-1:1];
          st_data = be[0] ? {2{data[LANE_W-1:0]}} : {2{data[PHYS_W-1:LANE_W]}};
          st_we   = wp[0] ? 2'b10 : 2'b01;
          commit  = 1'b1;
        end
        M_HALF: if (wr_lo) begin
          st_row = wp[ROW_W-1:0];
          st_we  = be;
          commit = be[1];
        end
        default: if (wr_lo) begin
          st_row = {wp[ROW_W-2:0], 1'b0};
          st_we  = be;
        end else if (wr_hi) begin
          st_row = {wp[ROW_W-2:0], 1'b1};
          st_we  = be;
          commit = hi_lane ? be[1] : be[0];
        end
      endcase
    end
  end

  // R3 R4: high-register writes never reach the store outside word mode
  a_r4_hi_ignored: assert property (@(posedge clk) disable iff (rst)
    (mode != M_WORD && wr_hi && !wr_lo) |-> (st_we == 2'b00 && !commit));
  // R12: with both strobes in word mode the low row is targeted
  a_r12_lo_first: assert property (@(posedge clk) disable iff (rst)
    (mode == M_WORD && wr_lo && wr_hi) |-> (!commit && st_row[0] == 1'b0));
endmodule

// File: rtl/crcin_fifo.sv
module crcin_fifo
  import crcin_pkg::*;
#(
  parameter int LANE_W = 8,
  parameter int ROWS   = 8,
  localparam int PHYS_W = 2 * LANE_W,
  localparam int DATA_W = 2 * PHYS_W,
  localparam int CODE_W = $clog2(DATA_W),
  localparam int CNT_W  = $clog2(2 * ROWS + 1),
  localparam int PTR_W  = $clog2(2 * ROWS),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [CODE_W-1:0] width_code,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [1:0]        wr_be,
  input  logic [PHYS_W-1:0] wr_data,
  input  logic              pop,
  output logic [CNT_W-1:0]  level,
  output logic              full,
  output logic              empty,
  output logic [DATA_W-1:0] word_data,
  output logic [PHYS_W-1:0] dreg_rdata
);
  fmode_t             mode;
  logic [CNT_W-1:0]   depth;
  logic [PTR_W-1:0]   depth_m1;
  logic [DATA_W-1:0]  mask;
  logic               hi_lane;
  logic [PTR_W-1:0]   wp, rp;
  logic [1:0]         st_we;
  logic [ROW_W-1:0]   st_row, rrow_a, rrow_b;
  logic [PHYS_W-1:0]  st_data, rdata_a, rdata_b;
  logic               commit, do_pop;
  logic [CNT_W-1:0]   level_nx;
  logic [DATA_W-1:0]  raw;

  crcin_mode_dec #(.LANE_W(LANE_W), .ROWS(ROWS)) u_dec (
    .code(width_code), .mode(mode), .depth(depth), .depth_m1(depth_m1),
    .mask(mask), .hi_lane(hi_lane)
  );

  crcin_wr_ctrl #(.LANE_W(LANE_W), .ROWS(ROWS)) u_wr (
    .clk(clk), .rst(rst), .mode(mode), .hi_lane(hi_lane),
    .accept(enable && !full), .wp(wp), .wr_lo(wr_lo), .wr_hi(wr_hi),
    .be(wr_be), .data(wr_data), .st_we(st_we), .st_row(st_row),
    .st_data(st_data), .commit(commit)
  );

  crcin_store #(.LANE_W(LANE_W), .ROWS(ROWS)) u_store (
    .clk(clk), .we(st_we), .wrow(st_row), .wdata(st_data),
    .rrow_a(rrow_a), .rrow_b(rrow_b), .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  assign do_pop     = enable && pop && (level != '0);
  assign level_nx   = level + CNT_W'(commit) - CNT_W'(do_pop);
  assign dreg_rdata = '0;

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      level <= '0;
      wp    <= '0;
      rp    <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      level <= level_nx;
      if (commit) wp <= (wp + PTR_W'(1)) & depth_m1;
      if (do_pop) rp <= (rp + PTR_W'(1)) & depth_m1;
      full  <= (level_nx == depth);
      empty <= (level_nx == '0);
    end
  end

  always_comb begin
    rrow_b = {rp[ROW_W-2:0], 1'b1};
    unique case (mode)
      M_BYTE: begin
        rrow_a = rp[PTR_W-1:1];
        raw    = DATA_W'(rp[0] ? rdata_a[PHYS_W-1:LANE_W] : rdata_a[LANE_W-1:0]);
      end
      M_HALF: begin
        rrow_a = rp[ROW_W-1:0];
        raw    = DATA_W'(rdata_a);
      end
      default: begin
        rrow_a = {rp[ROW_W-2:0], 1'b0};
        raw    = {rdata_b, rdata_a};
      end
    endcase
  end
  assign word_data = raw & mask;

  // R2: level bounded by the largest logical depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(2 * ROWS));
  // R6: a full queue without a pop keeps its level
  a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
    (enable && full && !pop) |=> (level == $past(level)));
  // R7: a pop from a full queue clears full
  a_r7_pop_full: assert property (@(posedge clk) disable iff (rst)
    (enable && full && pop) |=> !full);
  // R8: commit together with a pop leaves the level alone
  a_r8_push_pop: assert property (@(posedge clk) disable iff (rst)
    (enable && commit && pop && !empty) |=> (level == $past(level)));
  // R9: disable flushes at the next edge
  a_r9_flush: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (level == '0 && empty && !full));
endmodule

// File: tb/crcin_fifo_test.sv
module crcin_fifo_test;
  logic        clk = 1'b0;
  logic        rst, enable, wr_lo, wr_hi, pop;
  logic [4:0]  width_code;
  logic [1:0]  wr_be;
  logic [15:0] wr_data;
  logic [4:0]  level;
  logic        full, empty;
  logic [31:0] word_data;
  logic [15:0] dreg_rdata;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  crcin_fifo uut (
    .clk(clk), .rst(rst), .enable(enable), .width_code(width_code),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_be(wr_be), .wr_data(wr_data),
    .pop(pop), .level(level), .full(full), .empty(empty),
    .word_data(word_data), .dreg_rdata(dreg_rdata)
  );

  // op: 0 low write, 1 high write, 2 pop, 3 both strobes
  // {op[2], code[5], be[2], data[16], level[5], full, empty, head[32]}
  localparam int NV = 25;
  localparam logic [63:0] VEC [NV] = '{
    {2'd0, 5'd5,  2'b01, 16'h00FF, 5'd1, 1'b0, 1'b0, 32'h0000_003F}, // R3 R11
    {2'd0, 5'd5,  2'b10, 16'h2A00, 5'd2, 1'b0, 1'b0, 32'h0000_003F}, // R3
    {2'd0, 5'd5,  2'b11, 16'h1507, 5'd3, 1'b0, 1'b0, 32'h0000_003F}, // R3
    {2'd1, 5'd5,  2'b01, 16'h0011, 5'd3, 1'b0, 1'b0, 32'h0000_003F}, // R3
    {2'd2, 5'd5,  2'b00, 16'h0000, 5'd2, 1'b0, 1'b0, 32'h0000_002A}, // R7
    {2'd2, 5'd5,  2'b00, 16'h0000, 5'd1, 1'b0, 1'b0, 32'h0000_0007}, // R3
    {2'd2, 5'd5,  2'b00, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h0},
    {2'd2, 5'd5,  2'b00, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h0},          // R7
    {2'd0, 5'd11, 2'b01, 16'h0034, 5'd0, 1'b0, 1'b1, 32'h0},          // R4
    {2'd0, 5'd11, 2'b10, 16'hAB00, 5'd1, 1'b0, 1'b0, 32'h0000_0B34}, // R4 R11
    {2'd1, 5'd11, 2'b11, 16'hFFFF, 5'd1, 1'b0, 1'b0, 32'h0000_0B34}, // R4
    {2'd0, 5'd11, 2'b11, 16'h1234, 5'd2, 1'b0, 1'b0, 32'h0000_0B34},
    {2'd2, 5'd11, 2'b00, 16'h0000, 5'd1, 1'b0, 1'b0, 32'h0000_0234},
    {2'd2, 5'd11, 2'b00, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h0},
    {2'd0, 5'd23, 2'b11, 16'h5678, 5'd0, 1'b0, 1'b1, 32'h0},          // R5
    {2'd1, 5'd23, 2'b10, 16'h9900, 5'd0, 1'b0, 1'b1, 32'h0},          // R5
    {2'd1, 5'd23, 2'b01, 16'h0034, 5'd1, 1'b0, 1'b0, 32'h0034_5678}, // R5 R11
    {2'd2, 5'd23, 2'b00, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h0},
    {2'd0, 5'd31, 2'b11, 16'hBEEF, 5'd0, 1'b0, 1'b1, 32'h0},
    {2'd1, 5'd31, 2'b01, 16'h00AD, 5'd0, 1'b0, 1'b1, 32'h0},          // R5
    {2'd1, 5'd31, 2'b10, 16'hDE00, 5'd1, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R5
    {2'd3, 5'd31, 2'b11, 16'h1111, 5'd1, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R12
    {2'd1, 5'd31, 2'b11, 16'h2222, 5'd2, 1'b0, 1'b0, 32'hDEAD_BEEF}, // R12
    {2'd2, 5'd31, 2'b00, 16'h0000, 5'd1, 1'b0, 1'b0, 32'h2222_1111}, // R12
    {2'd2, 5'd31, 2'b00, 16'h0000, 5'd0, 1'b0, 1'b1, 32'h0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // called at a falling edge; holds the strobes across one rising edge
  task automatic drive(input logic lo, input logic hi, input logic [1:0] be,
                       input logic [15:0] d, input logic p);
    wr_lo = lo; wr_hi = hi; wr_be = be; wr_data = d; pop = p;
    @(negedge clk);
    wr_lo = 1'b0; wr_hi = 1'b0; wr_be = 2'b00; pop = 1'b0;
  endtask

  task automatic state(input string tag, input int lv, input logic f, input logic e);
    check({tag, " level"}, 32'(level), 32'(lv));
    check({tag, " full"},  32'(full),  32'(f));
    check({tag, " empty"}, 32'(empty), 32'(e));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; enable = 1'b0; width_code = 5'd5;
    wr_lo = 1'b0; wr_hi = 1'b0; wr_be = 2'b00; wr_data = '0; pop = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    state("R1 reset", 0, 1'b0, 1'b1);
    check("R10 read zero", 32'(dreg_rdata), 32'h0);
    enable = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [63:0] v;
      v = VEC[i];
      width_code = v[61:57];
      drive(v[63:62] != 2'd1, v[63:62] == 2'd1 || v[63:62] == 2'd3,
            v[56:55], v[54:39], v[63:62] == 2'd2);
      state($sformatf("R3-R12 vector %0d", i), int'(v[38:34]), v[33], v[32]);
      if (v[38:34] != 5'd0) check($sformatf("R11 vector %0d head", i), word_data, v[31:0]);
    end

    // R2 R6 R7: word mode to depth, writes while full, drain
    width_code = 5'd31;
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 1'b0, 2'b11, 16'h1000 + 16'(i), 1'b0);
      drive(1'b0, 1'b1, 2'b11, 16'hA000 + 16'(i), 1'b0);
    end
    state("R2 word depth", 4, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 2'b11, 16'hFFFF, 1'b0);
    drive(1'b0, 1'b1, 2'b11, 16'hFFFF, 1'b0);
    state("R6 write while full", 4, 1'b1, 1'b0);
    check("R6 head kept", word_data, 32'hA000_1000);
    check("R10 read zero busy", 32'(dreg_rdata), 32'h0);
    for (int i = 0; i < 4; i++) begin
      drive(1'b0, 1'b0, 2'b00, 16'h0, 1'b1);
      check("R7 pop level", 32'(level), 32'(3 - i));
      check("R7 full cleared", 32'(full), 32'h0);
      if (i < 3) check("R6 stored word", word_data, {16'hA001 + 16'(i), 16'h1001 + 16'(i)});
    end

    // R2 R8: byte mode to depth 16, then push and pop together
    width_code = 5'd7;
    for (int i = 0; i < 16; i++) begin
      drive(1'b1, 1'b0, 2'b01, 16'(8'(i * 7 + 3)), 1'b0);
      if (i == 14) state("R2 byte not yet full", 15, 1'b0, 1'b0);
    end
    state("R2 byte depth", 16, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 2'b00, 16'h0, 1'b1);
    check("R7 byte head", word_data, 32'(8'(1 * 7 + 3)));
    drive(1'b1, 1'b0, 2'b10, 16'h5A00, 1'b1);
    state("R8 push and pop", 15, 1'b0, 1'b0);
    check("R8 head advanced", word_data, 32'(8'(2 * 7 + 3)));
    repeat (14) drive(1'b0, 1'b0, 2'b00, 16'h0, 1'b1);
    check("R8 last byte", word_data, 32'h5A);
    drive(1'b0, 1'b0, 2'b00, 16'h0, 1'b1);
    state("R8 drained", 0, 1'b0, 1'b1);

    // R2 R9: halfword mode to depth 8, then disable
    width_code = 5'd15;
    for (int i = 0; i < 8; i++) drive(1'b1, 1'b0, 2'b11, 16'hC000 + 16'(i), 1'b0);
    state("R2 half depth", 8, 1'b1, 1'b0);
    check("R4 half head", word_data, 32'hC000);
    enable = 1'b0;
    @(negedge clk);
    state("R9 flush", 0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 2'b11, 16'h7777, 1'b0);
    state("R9 write while disabled", 0, 1'b0, 1'b1);
    enable = 1'b1;
    drive(1'b0, 1'b0, 2'b00, 16'h0, 1'b1);
    state("R9 re-enabled", 0, 1'b0, 1'b1);
    drive(1'b1, 1'b0, 2'b11, 16'h4321, 1'b0);
    state("R9 write after enable", 1, 1'b0, 1'b0);
    check("R9 fresh head", word_data, 32'h4321);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule